// File: doc/BRIEF.md
# Sampling Core Selection Controller

This controller chooses which of four cores, all running the same instruction set, executes the single active thread. Two of the cores are in-order designs and two are out-of-order designs. The running core reports the end of each interval. An interval is one million committed instructions. Each report carries the cycle count and the energy estimate for the interval that has just finished. Outside sampling, the controller keeps an exponential moving average of cycles per interval.

After a set number of counted intervals, the controller starts a trial. It moves the thread through every core in ascending index order. Each core runs for a fixed window of intervals, and the controller sums that core's cycles and energy. One cycle after the last trial interval, it commits to the core with the smallest energy among those whose cycles stay within 10% of the average. If no core meets that bound, it takes the fastest core instead.

Every real core switch holds the new core in a restart wait of fixed length. During that wait, interval reports are disregarded. Only the selected core keeps its power enable. All other cores are switched off.

Top module: `core_select_ctrl`

## Requirements
- R1: A synchronous active-high reset gives active_core = 0, core_pwr_en = 4'b0001 and restart_wait = 0.
- R2: core_pwr_en has exactly one bit set, bit i for core i, and that bit always equals the value on active_core.
- R3: Outside sampling, every accepted interval report increments a counter. The report that brings the count to SAMPLE_PERIOD starts a trial, and active_core goes to 0 on that report. The trial then runs cores 0, 1, 2, 3 in that order, and each core stays active for SAMPLE_WIN accepted reports.
- R4: A trial core passes when its summed cycles × 10 ≤ average × 11 × SAMPLE_WIN. Among the passing cores, the one with the smallest summed energy is chosen. An energy tie goes to the lower index.
- R5: When no core passes, the core with the smallest summed cycles is chosen. A tie goes to the lower index.
- R6: Every change of active_core to a different core that charges the restart penalty raises restart_wait for exactly RESTART_CYCLES cycles. The wait begins in the cycle in which the new active_core value first appears.
- R7: An interval report that arrives while restart_wait is high is ignored. It changes no count, no sum and no average.
- R8: The first accepted report after reset seeds the average with its cycle count. Every later report accepted outside sampling sets avg ← avg − (avg >> 3) + (cycles >> 3). Reports taken during a trial leave the average unchanged.
- R9: After a trial, no restart penalty is charged when the chosen core is the core that was active before the trial began, or when it is core 3, the core that is already running. Any other choice is charged the penalty.
- R10: The decision appears on active_core one cycle after the clock edge that accepts the final trial report. Normal interval counting then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ivl_done | input | 1 | One-cycle pulse marking the end of an interval on the running core |
| ivl_cycles | input | CYC_W | Cycles spent in the interval that has just finished |
| ivl_energy | input | NRG_W | Energy estimate for that interval |
| active_core | output | 2 | Index of the core that runs the thread |
| core_pwr_en | output | NUM_CORES | Power enable for each core, one-hot |
| restart_wait | output | 1 | High while the newly selected core is restarting |

## Verification
The bench builds the controller with a trial every 4 intervals, windows of 2 intervals and an 8-cycle restart penalty. With these values, six complete trials and their restart waits fit into a short run. Across the trials, the bench reaches:
- a decision that passes on the exact 10% boundary;
- a decision that misses the boundary by one cycle;
- energy ties;
- the fallback to the fastest core;
- a choice that returns to the core active before the trial, and a choice that stays on core 3.

One trial raises the average with slow normal intervals, so the outcome differs from the one a frozen average would give. A spurious report is injected during a restart wait and would change that trial's winner if it were counted.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_DECIDE = 2'd2
    } csel_state_e;

    typedef struct packed {
        logic       req;
        logic [1:0] core;
        logic       penalty;
    } csel_switch_t;

    function automatic logic [3:0] core_onehot(input logic [1:0] idx);
        return 4'b0001 << idx;
    endfunction

endpackage

// File: rtl/csel_restart_timer.sv
module csel_restart_timer #(
    parameter int RESTART_CYCLES = 1000,
    localparam int RST_W = $clog2(RESTART_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    logic [RST_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= RST_W'(RESTART_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - RST_W'(1);
    end

    assign busy = (cnt != '0);

    AST_WAIT_LOADED: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R6
    AST_WAIT_ENDS: assert property (@(posedge clk) disable iff (rst)
        (cnt == RST_W'(1) && !start) |=> !busy); // R6
endmodule

// File: rtl/csel_metric_store.sv
module csel_metric_store #(
    parameter int NUM_CORES = 4,
    parameter int CYC_W = 24,
    parameter int NRG_W = 24,
    parameter int SAMPLE_WIN = 5,
    localparam int CORE_W = $clog2(NUM_CORES),
    localparam int SUM_W = CYC_W + $clog2(SAMPLE_WIN + 1),
    localparam int ESUM_W = NRG_W + $clog2(SAMPLE_WIN + 1)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                clr,
    input  logic                                acc,
    input  logic [CORE_W-1:0]                   idx,
    input  logic [CYC_W-1:0]                    cyc,
    input  logic [NRG_W-1:0]                    nrg,
    output logic [NUM_CORES-1:0][SUM_W-1:0]     cyc_sum,
    output logic [NUM_CORES-1:0][ESUM_W-1:0]    nrg_sum
);
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                cyc_sum[g] <= '0;
                nrg_sum[g] <= '0;
            end else if (acc && idx == CORE_W'(g)) begin
                cyc_sum[g] <= cyc_sum[g] + SUM_W'(cyc);
                nrg_sum[g] <= nrg_sum[g] + ESUM_W'(nrg);
            end
        end
    end
endmodule

// File: rtl/csel_picker.sv
module csel_picker #(
    parameter int NUM_CORES = 4,
    parameter int CYC_W = 24,
    parameter int NRG_W = 24,
    parameter int SAMPLE_WIN = 5,
    parameter int BOUND_NUM = 11,
    parameter int BOUND_DEN = 10,
    localparam int CORE_W = $clog2(NUM_CORES),
    localparam int SUM_W = CYC_W + $clog2(SAMPLE_WIN + 1),
    localparam int ESUM_W = NRG_W + $clog2(SAMPLE_WIN + 1),
    localparam int PW = SUM_W + 16
) (
    input  logic [NUM_CORES-1:0][SUM_W-1:0]  cyc_sum,
    input  logic [NUM_CORES-1:0][ESUM_W-1:0] nrg_sum,
    input  logic [CYC_W-1:0]                 avg,
    output logic [CORE_W-1:0]                pick
);
    logic [NUM_CORES-1:0] ok;
    logic [PW-1:0]        rhs;

    assign rhs = PW'(avg) * PW'(BOUND_NUM) * PW'(SAMPLE_WIN);

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_bound
        assign ok[g] = (PW'(cyc_sum[g]) * PW'(BOUND_DEN)) <= rhs;
    end

    always_comb begin
        logic              found;
        logic [CORE_W-1:0] best;
        logic [CORE_W-1:0] fast;
        found = 1'b0;
        best  = '0;
        fast  = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (ok[i] && (!found || nrg_sum[i] < nrg_sum[best])) begin
                best  = CORE_W'(i);
                found = 1'b1;
            end
            if (cyc_sum[i] < cyc_sum[fast])
                fast = CORE_W'(i);
        end
        pick = found ? best : fast;
    end
endmodule

// File: rtl/core_select_ctrl.sv
module core_select_ctrl
    import csel_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CYC_W = 24,
    parameter int NRG_W = 24,
    parameter int SAMPLE_PERIOD = 100,
    parameter int SAMPLE_WIN = 5,
    parameter int RESTART_CYCLES = 1000,
    parameter int EMA_SHIFT = 3,
    localparam int CORE_W = $clog2(NUM_CORES),
    localparam int PER_W = $clog2(SAMPLE_PERIOD + 1),
    localparam int WIN_W = $clog2(SAMPLE_WIN + 1),
    localparam int SUM_W = CYC_W + $clog2(SAMPLE_WIN + 1),
    localparam int ESUM_W = NRG_W + $clog2(SAMPLE_WIN + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ivl_done,
    input  logic [CYC_W-1:0]     ivl_cycles,
    input  logic [NRG_W-1:0]     ivl_energy,
    output logic [1:0]           active_core,
    output logic [NUM_CORES-1:0] core_pwr_en,
    output logic                 restart_wait
);
    localparam logic [CORE_W-1:0] LAST = CORE_W'(NUM_CORES - 1);

    csel_state_e       state;
    logic [CORE_W-1:0] active, home, cand, pick;
    logic [PER_W-1:0]  ivl_cnt;
    logic [WIN_W-1:0]  win_cnt;
    logic [CYC_W-1:0]  avg, avg_ema;
    logic              seeded, ev, clr, acc, busy;
    csel_switch_t      sw;
    logic [NUM_CORES-1:0][SUM_W-1:0]  cyc_sum;
    logic [NUM_CORES-1:0][ESUM_W-1:0] nrg_sum;

    assign ev      = ivl_done && !busy;
    assign clr     = (state == ST_RUN) && ev && (ivl_cnt == PER_W'(SAMPLE_PERIOD - 1));
    assign acc     = (state == ST_SAMPLE) && ev;
    assign avg_ema = avg - (avg >> EMA_SHIFT) + (ivl_cycles >> EMA_SHIFT);

    always_comb begin
        sw = '0;
        unique case (state)
            ST_RUN: if (clr) begin
                sw.req     = 1'b1;
                sw.core    = 2'(0);
                sw.penalty = (active != '0);
            end
            ST_SAMPLE: if (acc && win_cnt == WIN_W'(SAMPLE_WIN - 1) && cand != LAST) begin
                sw.req     = 1'b1;
                sw.core    = 2'(cand + CORE_W'(1));
                sw.penalty = 1'b1;
            end
            ST_DECIDE: begin
                sw.req     = 1'b1;
                sw.core    = 2'(pick);
                sw.penalty = (pick != home) && (pick != active);
            end
            default: sw = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_RUN;
            active  <= '0;
            home    <= '0;
            cand    <= '0;
            ivl_cnt <= '0;
            win_cnt <= '0;
            avg     <= '0;
            seeded  <= 1'b0;
        end else begin
            if (sw.req)
                active <= CORE_W'(sw.core);
            unique case (state)
                ST_RUN: if (ev) begin
                    seeded <= 1'b1;
                    avg    <= seeded ? avg_ema : ivl_cycles;
                    if (clr) begin
                        ivl_cnt <= '0;
                        state   <= ST_SAMPLE;
                        home    <= active;
                        cand    <= '0;
                        win_cnt <= '0;
                    end else begin
                        ivl_cnt <= ivl_cnt + PER_W'(1);
                    end
                end
                ST_SAMPLE: if (ev) begin
                    if (win_cnt == WIN_W'(SAMPLE_WIN - 1)) begin
                        win_cnt <= '0;
                        if (cand == LAST)
                            state <= ST_DECIDE;
                        else
                            cand <= cand + CORE_W'(1);
                    end else begin
                        win_cnt <= win_cnt + WIN_W'(1);
                    end
                end
                ST_DECIDE: state <= ST_RUN;
                default:   state <= ST_RUN;
            endcase
        end
    end

    csel_metric_store #(
        .NUM_CORES(NUM_CORES), .CYC_W(CYC_W), .NRG_W(NRG_W), .SAMPLE_WIN(SAMPLE_WIN)
    ) u_store (
        .clk(clk), .rst(rst), .clr(clr), .acc(acc), .idx(cand),
        .cyc(ivl_cycles), .nrg(ivl_energy), .cyc_sum(cyc_sum), .nrg_sum(nrg_sum)
    );

    csel_picker #(
        .NUM_CORES(NUM_CORES), .CYC_W(CYC_W), .NRG_W(NRG_W), .SAMPLE_WIN(SAMPLE_WIN),
        .BOUND_NUM(11), .BOUND_DEN(10)
    ) u_pick (
        .cyc_sum(cyc_sum), .nrg_sum(nrg_sum), .avg(avg), .pick(pick)
    );

    csel_restart_timer #(
        .RESTART_CYCLES(RESTART_CYCLES)
    ) u_timer (
        .clk(clk), .rst(rst), .start(sw.req && sw.penalty), .busy(busy)
    );

    assign active_core  = 2'(active);
    assign core_pwr_en  = NUM_CORES'(core_onehot(2'(active)));
    assign restart_wait = busy;

    AST_WAIT_ON_SWITCH: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (active != $past(active))); // R6
    AST_CORE_HELD_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(active)); // R7
    AST_IGNORED_EVENT: assert property (@(posedge clk) disable iff (rst)
        (ivl_done && busy) |=> ($stable(win_cnt) && $stable(cand) && $stable(avg))); // R7
    AST_SAMPLE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SAMPLE) |-> (active == cand)); // R3
    AST_AVG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |=> $stable(avg)); // R8
    AST_DECIDE_ONCE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECIDE) |=> (state == ST_RUN && ivl_cnt == '0)); // R10
    AST_ONE_POWERED: assert property (@(posedge clk) disable iff (rst)
        $onehot(core_pwr_en)); // R2
endmodule

// File: tb/core_select_ctrl_bench.sv
module core_select_ctrl_bench;
    localparam int P = 4;
    localparam int W = 2;
    localparam int RC = 8;
    localparam int ROWS = 6;

    localparam int NV [ROWS] = '{1000, 1000, 1000, 1000, 1800, 1000};
    localparam int CY [ROWS][4] = '{
        '{1000, 1500, 1050, 900},
        '{2000, 1900, 1800, 1950},
        '{1000, 1100, 3000, 3000},
        '{1000, 1101, 1000, 2000},
        '{1400, 1465, 1500, 1200},
        '{1000, 1000, 1000, 1000}};
    localparam int EN [ROWS][4] = '{
        '{500, 100, 300, 400},
        '{1, 1, 1, 1},
        '{300, 300, 10, 10},
        '{300, 100, 300, 50},
        '{100, 200, 50, 400},
        '{9, 9, 9, 1}};

    logic        clk = 0;
    logic        rst = 1;
    logic        ivl_done = 0;
    logic [23:0] ivl_cycles = '0;
    logic [23:0] ivl_energy = '0;
    logic [1:0]  active_core;
    logic [3:0]  core_pwr_en;
    logic        restart_wait;

    int checks = 0;
    int fails = 0;
    int avgm = 0;
    bit seeded = 0;
    int cur = 0;
    bit done = 0;

    always #2 clk = ~clk;

    core_select_ctrl #(
        .CYC_W(24), .NRG_W(24), .SAMPLE_PERIOD(P), .SAMPLE_WIN(W), .RESTART_CYCLES(RC)
    ) u_core_select_ctrl (
        .clk(clk), .rst(rst), .ivl_done(ivl_done), .ivl_cycles(ivl_cycles),
        .ivl_energy(ivl_energy), .active_core(active_core),
        .core_pwr_en(core_pwr_en), .restart_wait(restart_wait)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int cyc, input int nrg);
        @(negedge clk);
        while (restart_wait) @(negedge clk);
        ivl_done   = 1;
        ivl_cycles = 24'(cyc);
        ivl_energy = 24'(nrg);
        @(negedge clk);
        ivl_done = 0;
    endtask

    task automatic count_wait(input bit inject, output int n);
        n = 0;
        while (restart_wait) begin
            if (inject && n == 0) begin
                ivl_done = 1; ivl_cycles = 24'd1; ivl_energy = 24'd1;
            end else begin
                ivl_done = 0;
            end
            n++;
            @(negedge clk);
        end
        ivl_done = 0;
    endtask

    function automatic int model_pick(input int r, input int avg);
        int best = -1;
        int fast = 0;
        for (int i = 0; i < 4; i++) begin
            if (CY[r][i] * W * 10 <= avg * 11 * W)
                if (best < 0 || EN[r][i] < EN[r][best]) best = i;
            if (CY[r][i] < CY[r][fast]) fast = i;
        end
        return (best >= 0) ? best : fast;
    endfunction

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 active after reset", active_core, 0);
        check("R1 power after reset", core_pwr_en, 1);
        check("R1 wait after reset", restart_wait, 0);

        for (int r = 0; r < ROWS; r++) begin
            int home;
            int p;
            int pen;
            for (int k = 0; k < P; k++) begin
                send(NV[r], 1);
                if (!seeded) begin avgm = NV[r]; seeded = 1; end
                else avgm = avgm - (avgm >> 3) + (NV[r] >> 3);
            end
            home = cur;
            check("R3 trial starts on core 0", active_core, 0);
            check("R2 power follows core 0", core_pwr_en, 1);
            count_wait(0, n);
            check("R6 wait length on trial entry", n, (cur != 0) ? RC : 0);
            for (int k = 0; k < 4; k++) begin
                for (int j = 0; j < W; j++) send(CY[r][k], EN[r][k]);
                if (k < 3) begin
                    check("R3 next trial core", active_core, k + 1);
                    check("R2 power one-hot", core_pwr_en, 1 << (k + 1));
                    count_wait(r == 0 && k == 0, n);
                    check("R6 R7 restart wait length", n, RC);
                end
            end
            @(negedge clk);
            p = model_pick(r, avgm);
            pen = (p != home && p != 3) ? 1 : 0;
            check("R4 R5 R8 R10 chosen core", active_core, p);
            check("R2 power on chosen core", core_pwr_en, 1 << p);
            check("R9 penalty after trial", restart_wait, pen);
            count_wait(0, n);
            check("R6 R9 wait after decision", n, pen ? RC : 0);
            cur = p;
        end

        for (int k = 0; k < P; k++) send(1000, 1);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1 active after mid-run reset", active_core, 0);
        check("R1 power after mid-run reset", core_pwr_en, 1);
        check("R1 wait after mid-run reset", restart_wait, 0);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule